// File: doc/BRIEF.md
# Triggered Command Set Mailbox

This block holds a bank of command sets. Every set has the same number of command slots. A slot keeps five 32-bit words: a header, a target address, a value, a status word and a response word. Software fills the slots through a word-addressed register port and picks which slots of a set take part with a per-set slot mask. When a set is started, the sequencer walks that set's slots from the lowest index to the highest. It skips the slots whose mask bit is clear and presents each enabled slot as an (address, value) request on a request/acknowledge bus. Once the last slot has been handled, the set's interrupt pending bit is raised.

Each set index belongs to one of four classes, in index order: sleep sets first, then wake, active and control. The number of sets in each class is a parameter, and any class may have none. The class decides which trigger source may start the set. Software starts a set by writing its trigger word. Firmware, or the idle logic once all processors are powered off, starts sets through a per-set trigger input. Only one set is on the bus at a time. Sets waiting to start are served lowest index first.

Register address layout, from the MSB down: `{global, set, slot, word[2:0]}`.
- With global=0, the word field selects a slot word: 0 header (bit 0 = read command), 1 address, 2 value, 3 status, 4 response.
- With global=1, the slot field is ignored and the word field selects a per-set word: 0 slot mask, 1 set status (bit 0 busy, bit 1 error), 2 trigger (write bit 0 = 1). It can also select one of two words shared by all sets: 3 interrupt pending, 4 interrupt enable.

Top module: `cmdset_mbx`

## Requirements
- R1: Header, address and value words of every slot are written by a register write and read back unchanged. Writes to a slot's status word (word 3) or response word (word 4) are ignored.
- R2: A started set issues one bus request per enabled slot, in ascending slot order, and skips disabled slots. `cmd_addr` carries the slot address and `cmd_wdata` the slot value. `cmd_we` is the inverse of header bit 0.
- R3: Class gating follows set index order (sleep, wake, active, control). Sleep and control sets accept only `fw_trig`. Active sets accept only the software trigger (global word 2, bit 0). Wake sets accept either source.
- R4: A trigger from a source the class does not permit does not start the set. It sets the sticky error bit (set status bit 1), which is cleared by writing 1 to that bit.
- R5: Slot status bit 0 is set when the slot's request is issued and bit 1 when it is acknowledged. All slot status words of a set are cleared when a trigger for that set is accepted.
- R6: For a read command (header bit 0 = 1), `cmd_rdata` at the acknowledge is stored in that slot's response word. Write commands leave the response word unchanged.
- R7: Only one set drives the bus at a time. Sets triggered in the same cycle run in ascending set index order.
- R8: A set reads busy (set status bit 0) from the accepted trigger until its completion. Triggers to a busy set are ignored and do not cause a second run.
- R9: Completion of a set sets its pending bit (global word 3, bit = set index), also when no slot is enabled. Writing 1 clears a pending bit. `irq` is high while any pending bit has its enable bit (global word 4) set.
- R10: Once raised, `cmd_req` stays high with stable address, value and direction until `cmd_ack`.
- R11: After reset all registers read zero, and `irq` and `cmd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| fw_trig | input | NSET | Firmware/idle trigger, one bit per set |
| cmd_req | output | 1 | Bus request valid |
| cmd_we | output | 1 | Bus request is a write |
| cmd_addr | output | DW | Bus request address |
| cmd_wdata | output | DW | Bus request value |
| cmd_ack | input | 1 | Bus acknowledge |
| cmd_rdata | input | DW | Bus read response |
| irq | output | 1 | Completion interrupt |

## Verification
A corrupted slot pointer or mask lookup shows up on the bus as a missing, extra or reordered request. This is visible within one acknowledge of the faulty slot. A wrong class decode or busy flag shows up within a few cycles of a trigger: a run starts where the error bit should be set, or the error bit is set where a run should start, or a busy set runs twice. Errors in status or response capture are seen by reading the slot words back once the pending bit rises.

// File: rtl/cmdset_pkg.sv
package cmdset_pkg;

   typedef enum logic [1:0] {
      CLS_SLEEP,
      CLS_WAKE,
      CLS_ACTIVE,
      CLS_CTRL
   } set_class_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_SCAN,
      SQ_WAIT,
      SQ_FIN
   } sq_state_e;

   // slot word codes (global bit = 0)
   localparam logic [2:0] WD_HDR = 3'd0;
   localparam logic [2:0] WD_ADR = 3'd1;
   localparam logic [2:0] WD_DAT = 3'd2;
   localparam logic [2:0] WD_STS = 3'd3;
   localparam logic [2:0] WD_RSP = 3'd4;

   // per-set and shared word codes (global bit = 1)
   localparam logic [2:0] GW_MASK = 3'd0;
   localparam logic [2:0] GW_STAT = 3'd1;
   localparam logic [2:0] GW_TRIG = 3'd2;
   localparam logic [2:0] GW_PEND = 3'd3;
   localparam logic [2:0] GW_IEN  = 3'd4;

   function automatic set_class_e class_of(int idx, int ns, int nw, int na);
      if (idx < ns)                return CLS_SLEEP;
      else if (idx < ns + nw)      return CLS_WAKE;
      else if (idx < ns + nw + na) return CLS_ACTIVE;
      else                         return CLS_CTRL;
   endfunction

   function automatic logic class_sw_ok(set_class_e c);
      return (c == CLS_WAKE) || (c == CLS_ACTIVE);
   endfunction

   function automatic logic class_fw_ok(set_class_e c);
      return (c != CLS_ACTIVE);
   endfunction

endpackage

// File: rtl/cmdset_slots.sv
module cmdset_slots #(
   parameter int NSET   = 9,
   parameter int N_SLOT = 8,
   parameter int DW     = 32,
   parameter int SETW   = 4,
   parameter int SLW    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   // software slot access
   input  logic              slot_we,
   input  logic [SETW-1:0]   a_set,
   input  logic [SLW-1:0]    a_slot,
   input  logic [2:0]        a_word,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     slot_rd,
   // slot masks
   input  logic              mask_we,
   output logic [N_SLOT-1:0] mask_rd,
   // sequencer side
   input  logic [SETW-1:0]   sq_set,
   input  logic [SLW-1:0]    sq_slot,
   output logic [N_SLOT-1:0] sq_mask,
   output logic              sq_rd_cmd,
   output logic [DW-1:0]     sq_addr,
   output logic [DW-1:0]     sq_data,
   input  logic [NSET-1:0]   clr_v,
   input  logic              iss,
   input  logic              cmp,
   input  logic              cmp_read,
   input  logic [DW-1:0]     cmp_rdata
);
   import cmdset_pkg::*;

   logic [DW-1:0]     hdr_q [NSET][N_SLOT];
   logic [DW-1:0]     adr_q [NSET][N_SLOT];
   logic [DW-1:0]     dat_q [NSET][N_SLOT];
   logic [DW-1:0]     rsp_q [NSET][N_SLOT];
   logic [1:0]        sts_q [NSET][N_SLOT];
   logic [N_SLOT-1:0] msk_q [NSET];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSET; s++) begin
            msk_q[s] <= '0;
            for (int k = 0; k < N_SLOT; k++) begin
               hdr_q[s][k] <= '0;
               adr_q[s][k] <= '0;
               dat_q[s][k] <= '0;
               rsp_q[s][k] <= '0;
               sts_q[s][k] <= '0;
            end
         end
      end else begin
         if (slot_we) begin
            case (a_word)
               WD_HDR:  hdr_q[a_set][a_slot] <= wdata;
               WD_ADR:  adr_q[a_set][a_slot] <= wdata;
               WD_DAT:  dat_q[a_set][a_slot] <= wdata;
               default: ;
            endcase
         end
         if (mask_we) msk_q[a_set] <= wdata[N_SLOT-1:0];
         for (int s = 0; s < NSET; s++) begin
            if (clr_v[s]) begin
               for (int k = 0; k < N_SLOT; k++) sts_q[s][k] <= '0;
            end
         end
         if (iss) sts_q[sq_set][sq_slot][0] <= 1'b1;
         if (cmp) begin
            sts_q[sq_set][sq_slot][1] <= 1'b1;
            if (cmp_read) rsp_q[sq_set][sq_slot] <= cmp_rdata;
         end
      end
   end

   always_comb begin
      case (a_word)
         WD_HDR:  slot_rd = hdr_q[a_set][a_slot];
         WD_ADR:  slot_rd = adr_q[a_set][a_slot];
         WD_DAT:  slot_rd = dat_q[a_set][a_slot];
         WD_STS:  slot_rd = DW'(sts_q[a_set][a_slot]);
         WD_RSP:  slot_rd = rsp_q[a_set][a_slot];
         default: slot_rd = '0;
      endcase
   end

   assign mask_rd   = msk_q[a_set];
   assign sq_mask   = msk_q[sq_set];
   assign sq_rd_cmd = hdr_q[sq_set][sq_slot][0];
   assign sq_addr   = adr_q[sq_set][sq_slot];
   assign sq_data   = dat_q[sq_set][sq_slot];

endmodule

// File: rtl/cmdset_trig.sv
module cmdset_trig #(
   parameter int N_SLEEP  = 3,
   parameter int N_WAKE   = 3,
   parameter int N_ACTIVE = 2,
   parameter int NSET     = 9,
   parameter int SETW     = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSET-1:0] sw_trig,
   input  logic [NSET-1:0] fw_trig,
   input  logic [NSET-1:0] err_clr,
   input  logic [NSET-1:0] done_v,
   input  logic            seq_idle,
   output logic [NSET-1:0] busy_v,
   output logic [NSET-1:0] err_q,
   output logic [NSET-1:0] accept,
   output logic            grant,
   output logic [SETW-1:0] grant_idx
);
   import cmdset_pkg::*;

   logic [NSET-1:0] sw_ok, fw_ok, ok_req, bad_req, queued_q, grant_v;

   for (genvar i = 0; i < NSET; i++) begin : g_cls
      localparam set_class_e CLS = class_of(i, N_SLEEP, N_WAKE, N_ACTIVE);
      assign sw_ok[i] = class_sw_ok(CLS);
      assign fw_ok[i] = class_fw_ok(CLS);
   end

   assign ok_req  = (sw_trig & sw_ok) | (fw_trig & fw_ok);
   assign bad_req = (sw_trig & ~sw_ok) | (fw_trig & ~fw_ok);
   assign accept  = ok_req & ~busy_v;

   // lowest queued index wins when the sequencer is free
   always_comb begin
      grant     = 1'b0;
      grant_idx = '0;
      grant_v   = '0;
      if (seq_idle) begin
         for (int i = 0; i < NSET; i++) begin
            if (!grant && queued_q[i]) begin
               grant      = 1'b1;
               grant_idx  = SETW'(i);
               grant_v[i] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_v   <= '0;
         queued_q <= '0;
         err_q    <= '0;
      end else begin
         busy_v   <= (busy_v | accept) & ~done_v;
         queued_q <= (queued_q | accept) & ~grant_v;
         err_q    <= (err_q & ~err_clr) | bad_req;
      end
   end

endmodule

// File: rtl/cmdset_seq.sv
module cmdset_seq #(
   parameter int N_SLOT = 8,
   parameter int DW     = 32,
   parameter int SETW   = 4,
   parameter int SLW    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SETW-1:0]   start_set,
   input  logic [N_SLOT-1:0] slot_en,
   input  logic              slot_rd_cmd,
   input  logic [DW-1:0]     slot_addr,
   input  logic [DW-1:0]     slot_data,
   output logic              idle,
   output logic [SETW-1:0]   cur_set,
   output logic [SLW-1:0]    cur_slot,
   output logic              iss,
   output logic              cmp,
   output logic              cmp_read,
   output logic              done,
   output logic              cmd_req,
   output logic              cmd_we,
   output logic [DW-1:0]     cmd_addr,
   output logic [DW-1:0]     cmd_wdata,
   input  logic              cmd_ack
);
   import cmdset_pkg::*;

   localparam logic [SLW-1:0] LAST = SLW'(N_SLOT - 1);

   sq_state_e     st_q;
   logic          rd_q;
   logic [DW-1:0] adr_q, dat_q;
   logic          last;

   assign last = (cur_slot == LAST);
   assign idle = (st_q == SQ_IDLE);
   assign iss  = (st_q == SQ_SCAN) && slot_en[cur_slot];
   assign cmp  = (st_q == SQ_WAIT) && cmd_ack;
   assign done = (st_q == SQ_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         cur_set  <= '0;
         cur_slot <= '0;
         rd_q     <= 1'b0;
         adr_q    <= '0;
         dat_q    <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: if (start) begin
               cur_set  <= start_set;
               cur_slot <= '0;
               st_q     <= SQ_SCAN;
            end
            SQ_SCAN: begin
               if (slot_en[cur_slot]) begin
                  rd_q  <= slot_rd_cmd;
                  adr_q <= slot_addr;
                  dat_q <= slot_data;
                  st_q  <= SQ_WAIT;
               end else if (last) begin
                  st_q <= SQ_FIN;
               end else begin
                  cur_slot <= cur_slot + SLW'(1);
               end
            end
            SQ_WAIT: if (cmd_ack) begin
               if (last) begin
                  st_q <= SQ_FIN;
               end else begin
                  cur_slot <= cur_slot + SLW'(1);
                  st_q     <= SQ_SCAN;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign cmp_read  = rd_q;
   assign cmd_req   = (st_q == SQ_WAIT);
   assign cmd_we    = ~rd_q;
   assign cmd_addr  = adr_q;
   assign cmd_wdata = dat_q;

endmodule

// File: rtl/cmdset_mbx.sv
module cmdset_mbx #(
   parameter int N_SLEEP  = 3,
   parameter int N_WAKE   = 3,
   parameter int N_ACTIVE = 2,
   parameter int N_CTRL   = 1,
   parameter int N_SLOT   = 8,
   parameter int DW       = 32,
   localparam int NSET    = N_SLEEP + N_WAKE + N_ACTIVE + N_CTRL,
   localparam int SETW    = (NSET > 1) ? $clog2(NSET) : 1,
   localparam int SLW     = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
   localparam int AW      = 1 + SETW + SLW + 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [AW-1:0]   reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   input  logic [NSET-1:0] fw_trig,
   output logic            cmd_req,
   output logic            cmd_we,
   output logic [DW-1:0]   cmd_addr,
   output logic [DW-1:0]   cmd_wdata,
   input  logic            cmd_ack,
   input  logic [DW-1:0]   cmd_rdata,
   output logic            irq
);
   import cmdset_pkg::*;

   if (NSET < 1) begin : g_bad_nset
      $error("cmdset_mbx: at least one command set is required");
   end
   if (N_SLOT < 1 || N_SLOT > DW) begin : g_bad_slot
      $error("cmdset_mbx: N_SLOT must lie in 1..DW");
   end
   if (NSET > DW) begin : g_bad_width
      $error("cmdset_mbx: NSET must not exceed DW");
   end
   if (DW < 2) begin : g_bad_dw
      $error("cmdset_mbx: DW must be at least 2");
   end

   // address decode
   logic              glb;
   logic [SETW-1:0]   a_set;
   logic [SLW-1:0]    a_slot;
   logic [2:0]        a_word;
   logic              set_ok;

   assign glb    = reg_addr[AW-1];
   assign a_set  = reg_addr[3+SLW +: SETW];
   assign a_slot = reg_addr[3 +: SLW];
   assign a_word = reg_addr[2:0];
   assign set_ok = (int'(a_set) < NSET);

   logic [NSET-1:0]   sw_trig, err_clr, done_v, busy_v, err_q, accept, pend_q, ien_q;
   logic              grant, seq_idle, seq_done, iss, cmp, cmp_read, sq_rd_cmd;
   logic [SETW-1:0]   grant_idx, cur_set;
   logic [SLW-1:0]    cur_slot;
   logic [N_SLOT-1:0] sq_mask, mask_rd;
   logic [DW-1:0]     sq_addr, sq_data, slot_rd;
   logic              gwr;

   assign gwr = reg_wr && glb && set_ok;

   for (genvar i = 0; i < NSET; i++) begin : g_set
      logic hit;
      assign hit        = gwr && (a_set == SETW'(i));
      assign sw_trig[i] = hit && (a_word == GW_TRIG) && reg_wdata[0];
      assign err_clr[i] = hit && (a_word == GW_STAT) && reg_wdata[1];
      assign done_v[i]  = seq_done && (cur_set == SETW'(i));
   end

   cmdset_slots #(
      .NSET(NSET), .N_SLOT(N_SLOT), .DW(DW), .SETW(SETW), .SLW(SLW)
   ) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_we  (reg_wr && !glb && set_ok),
      .a_set    (a_set),
      .a_slot   (a_slot),
      .a_word   (a_word),
      .wdata    (reg_wdata),
      .slot_rd  (slot_rd),
      .mask_we  (gwr && (a_word == GW_MASK)),
      .mask_rd  (mask_rd),
      .sq_set   (cur_set),
      .sq_slot  (cur_slot),
      .sq_mask  (sq_mask),
      .sq_rd_cmd(sq_rd_cmd),
      .sq_addr  (sq_addr),
      .sq_data  (sq_data),
      .clr_v    (accept),
      .iss      (iss),
      .cmp      (cmp),
      .cmp_read (cmp_read),
      .cmp_rdata(cmd_rdata)
   );

   cmdset_trig #(
      .N_SLEEP(N_SLEEP), .N_WAKE(N_WAKE), .N_ACTIVE(N_ACTIVE),
      .NSET(NSET), .SETW(SETW)
   ) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_trig  (sw_trig),
      .fw_trig  (fw_trig),
      .err_clr  (err_clr),
      .done_v   (done_v),
      .seq_idle (seq_idle),
      .busy_v   (busy_v),
      .err_q    (err_q),
      .accept   (accept),
      .grant    (grant),
      .grant_idx(grant_idx)
   );

   cmdset_seq #(
      .N_SLOT(N_SLOT), .DW(DW), .SETW(SETW), .SLW(SLW)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (grant),
      .start_set  (grant_idx),
      .slot_en    (sq_mask),
      .slot_rd_cmd(sq_rd_cmd),
      .slot_addr  (sq_addr),
      .slot_data  (sq_data),
      .idle       (seq_idle),
      .cur_set    (cur_set),
      .cur_slot   (cur_slot),
      .iss        (iss),
      .cmp        (cmp),
      .cmp_read   (cmp_read),
      .done       (seq_done),
      .cmd_req    (cmd_req),
      .cmd_we     (cmd_we),
      .cmd_addr   (cmd_addr),
      .cmd_wdata  (cmd_wdata),
      .cmd_ack    (cmd_ack)
   );

   // interrupt pending / enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         ien_q  <= '0;
      end else begin
         if (gwr && (a_word == GW_PEND))
            pend_q <= (pend_q & ~reg_wdata[NSET-1:0]) | done_v;
         else
            pend_q <= pend_q | done_v;
         if (gwr && (a_word == GW_IEN)) ien_q <= reg_wdata[NSET-1:0];
      end
   end

   assign irq = |(pend_q & ien_q);

   always_comb begin
      reg_rdata = '0;
      if (set_ok) begin
         if (!glb) begin
            reg_rdata = slot_rd;
         end else begin
            case (a_word)
               GW_MASK: reg_rdata = DW'(mask_rd);
               GW_STAT: reg_rdata = DW'({err_q[a_set], busy_v[a_set]});
               GW_PEND: reg_rdata = DW'(pend_q);
               GW_IEN:  reg_rdata = DW'(ien_q);
               default: reg_rdata = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/cmdset_mbx_chk.sv
module cmdset_mbx_chk #(
   parameter int N_SLEEP  = 3,
   parameter int N_WAKE   = 3,
   parameter int N_ACTIVE = 2,
   parameter int NSET     = 9,
   parameter int DW       = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_req,
   input logic            cmd_ack,
   input logic            cmd_we,
   input logic [DW-1:0]   cmd_addr,
   input logic [DW-1:0]   cmd_wdata,
   input logic [NSET-1:0] busy_v,
   input logic [NSET-1:0] done_v,
   input logic [NSET-1:0] sw_trig,
   input logic [NSET-1:0] fw_trig,
   input logic [NSET-1:0] pend_q
);
   import cmdset_pkg::*;

   logic [NSET-1:0] sw_allowed;
   for (genvar i = 0; i < NSET; i++) begin : g_ok
      localparam set_class_e C = class_of(i, N_SLEEP, N_WAKE, N_ACTIVE);
      assign sw_allowed[i] = class_sw_ok(C);
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_we))); // R10

   AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> (busy_v != '0)); // R8

   AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_v)); // R7

   AST_SW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_trig & ~sw_allowed & ~fw_trig & ~busy_v) != '0)
      |=> ((busy_v & $past(sw_trig & ~sw_allowed & ~fw_trig & ~busy_v)) == '0)); // R3

   AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_v == '0) |=> ((busy_v & $past(busy_v)) == $past(busy_v))); // R8

   AST_DONE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_v != '0) |=> ((pend_q & $past(done_v)) == $past(done_v))); // R9

endmodule

bind cmdset_mbx cmdset_mbx_chk #(
   .N_SLEEP(N_SLEEP), .N_WAKE(N_WAKE), .N_ACTIVE(N_ACTIVE), .NSET(NSET), .DW(DW)
) u_chk (.*);

// File: tb/cmdset_mbx_tb_top.sv
`timescale 1ns/1ps
module cmdset_mbx_tb_top;

   localparam int DW = 32;
   localparam int AW = 8;   // 1 + 2 (set) + 2 (slot) + 3 (word)

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [3:0]    fw_trig = '0;
   logic          cmd_req, cmd_we, irq;
   logic [DW-1:0] cmd_addr, cmd_wdata;
   logic          cmd_ack = 1'b0;
   logic [DW-1:0] cmd_rdata = '0;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int wcnt = 0;
   int log_n = 0;
   logic [DW-1:0] log_a [0:255];
   logic [DW-1:0] log_d [0:255];
   logic          log_w [0:255];

   always #4 clk = ~clk;

   cmdset_mbx #(
      .N_SLEEP(1), .N_WAKE(1), .N_ACTIVE(1), .N_CTRL(1), .N_SLOT(4), .DW(DW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fw_trig(fw_trig),
      .cmd_req(cmd_req), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
      .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata), .irq(irq)
   );

   // bus responder: acknowledges after lat extra cycles, logs each request
   always @(negedge clk) begin
      if (cmd_ack) begin
         cmd_ack = 1'b0;
         wcnt = 0;
      end else if (cmd_req) begin
         if (wcnt >= lat) begin
            cmd_ack = 1'b1;
            cmd_rdata = cmd_addr ^ 32'h5A5A_0000;
            if (log_n < 256) begin
               log_a[log_n] = cmd_addr;
               log_d[log_n] = cmd_wdata;
               log_w[log_n] = cmd_we;
            end
            log_n++;
         end else begin
            wcnt++;
         end
      end
   end

   function automatic logic [AW-1:0] ra(input logic g, input int set, input int slot, input logic [2:0] w);
      return {g, 2'(set), 2'(slot), w};
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_pend(input logic [3:0] want);
      logic [DW-1:0] v;
      for (int n = 0; n < 500; n++) begin
         rd(ra(1, 0, 0, 3'd3), v);
         if ((v[3:0] & want) == want) break;
      end
   endtask

   task automatic pulse_fw(input logic [3:0] v);
      @(negedge clk); fw_trig = v;
      @(negedge clk); fw_trig = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] v;
      logic [DW-1:0] mrsp [4];
      int base, k;
      for (int s = 0; s < 4; s++) mrsp[s] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      @(negedge clk); #1;
      chk("R11 irq", DW'(irq), 0);
      chk("R11 cmd_req", DW'(cmd_req), 0);
      rd(ra(1, 0, 0, 3'd3), v); chk("R11 pend", v, 0);
      rd(ra(1, 3, 0, 3'd1), v); chk("R11 status", v, 0);
      rd(ra(1, 1, 0, 3'd0), v); chk("R11 mask", v, 0);
      rd(ra(0, 2, 1, 3'd4), v); chk("R11 rsp", v, 0);

      // R1 slot storage
      wr(ra(0, 1, 3, 3'd0), 32'h0000_0001);
      wr(ra(0, 1, 3, 3'd1), 32'hCAFE_0013);
      wr(ra(0, 1, 3, 3'd2), 32'h1234_5678);
      wr(ra(0, 1, 3, 3'd3), 32'hFFFF_FFFF);
      wr(ra(0, 1, 3, 3'd4), 32'hFFFF_FFFF);
      rd(ra(0, 1, 3, 3'd0), v); chk("R1 hdr", v, 32'h0000_0001);
      rd(ra(0, 1, 3, 3'd1), v); chk("R1 addr", v, 32'hCAFE_0013);
      rd(ra(0, 1, 3, 3'd2), v); chk("R1 data", v, 32'h1234_5678);
      rd(ra(0, 1, 3, 3'd3), v); chk("R1 status ro", v, 0);
      rd(ra(0, 1, 3, 3'd4), v); chk("R1 rsp ro", v, 0);
      wr(ra(0, 1, 3, 3'd0), 0);

      wr(ra(1, 0, 0, 3'd4), 32'hF);

      // R2 R5 R6 R9: every slot mask of the active set
      for (int m = 0; m < 16; m++) begin
         for (int s = 0; s < 4; s++) begin
            wr(ra(0, 2, s, 3'd0), DW'(((s + m) & 1)));
            wr(ra(0, 2, s, 3'd1), 32'h1000_0000 + DW'(m << 8) + DW'(s));
            wr(ra(0, 2, s, 3'd2), 32'hD000_0000 + DW'(m * 16) + DW'(s));
         end
         wr(ra(1, 2, 0, 3'd0), DW'(m));
         base = log_n;
         wr(ra(1, 2, 0, 3'd2), 1);
         wait_pend(4'b0100);
         repeat (2) @(negedge clk);
         k = base;
         for (int s = 0; s < 4; s++) begin
            if (m[s]) begin
               chk($sformatf("R2 m%0d s%0d addr", m, s), log_a[k], 32'h1000_0000 + DW'(m << 8) + DW'(s));
               chk($sformatf("R2 m%0d s%0d data", m, s), log_d[k], 32'hD000_0000 + DW'(m * 16) + DW'(s));
               chk($sformatf("R2 m%0d s%0d we", m, s), DW'(log_w[k]), DW'(((s + m) & 1) == 0));
               k++;
               if (((s + m) & 1) == 1) mrsp[s] = (32'h1000_0000 + DW'(m << 8) + DW'(s)) ^ 32'h5A5A_0000;
            end
         end
         chk($sformatf("R2 m%0d count", m), DW'(log_n - base), DW'($countones(m)));
         for (int s = 0; s < 4; s++) begin
            rd(ra(0, 2, s, 3'd3), v);
            chk($sformatf("R5 m%0d s%0d status", m, s), v, m[s] ? 32'h3 : 32'h0);
            rd(ra(0, 2, s, 3'd4), v);
            chk($sformatf("R6 m%0d s%0d rsp", m, s), v, mrsp[s]);
         end
         rd(ra(1, 0, 0, 3'd3), v); chk("R9 pend set", v, 32'h4);
         wr(ra(1, 0, 0, 3'd3), 32'h4);
         @(negedge clk); #1;
         chk("R9 irq cleared", DW'(irq), 0);
      end

      // R3 R4 class gating, all masks zero
      wr(ra(1, 2, 0, 3'd0), 0);
      for (int set = 0; set < 4; set++) begin
         for (int src = 0; src < 2; src++) begin
            logic ok;
            ok = (src == 0) ? (set == 1 || set == 2) : (set != 2);
            if (src == 0) wr(ra(1, set, 0, 3'd2), 1);
            else pulse_fw(4'(1 << set));
            repeat (20) @(negedge clk);
            rd(ra(1, 0, 0, 3'd3), v);
            chk($sformatf("R3 set%0d src%0d pend", set, src), DW'(v[set]), DW'(ok));
            rd(ra(1, set, 0, 3'd1), v);
            chk($sformatf("R4 set%0d src%0d err", set, src), DW'(v[1]), DW'(!ok));
            wr(ra(1, set, 0, 3'd1), 32'h2);
            rd(ra(1, set, 0, 3'd1), v);
            chk($sformatf("R4 set%0d err w1c", set), v, 0);
            wr(ra(1, 0, 0, 3'd3), 32'hF);
         end
      end

      // R7 priority among simultaneous firmware triggers
      for (int set = 0; set < 4; set++) begin
         wr(ra(0, set, 0, 3'd0), 0);
         wr(ra(0, set, 0, 3'd1), 32'hA000_0000 + DW'(set));
      end
      for (int set = 0; set < 4; set++) if (set != 2) wr(ra(1, set, 0, 3'd0), 1);
      lat = 2;
      base = log_n;
      pulse_fw(4'b1011);
      wait_pend(4'b1011);
      chk("R7 count", DW'(log_n - base), 3);
      chk("R7 first", log_a[base], 32'hA000_0000);
      chk("R7 second", log_a[base + 1], 32'hA000_0001);
      chk("R7 third", log_a[base + 2], 32'hA000_0003);
      wr(ra(1, 0, 0, 3'd3), 32'hF);

      // R8 busy window and retrigger while busy
      wr(ra(1, 2, 0, 3'd0), 32'h3);
      lat = 6;
      base = log_n;
      wr(ra(1, 2, 0, 3'd2), 1);
      repeat (3) @(negedge clk);
      rd(ra(1, 2, 0, 3'd1), v); chk("R8 busy", v, 32'h1);
      wr(ra(1, 2, 0, 3'd2), 1);
      wait_pend(4'b0100);
      rd(ra(1, 2, 0, 3'd1), v); chk("R8 idle after", v, 0);
      repeat (30) @(negedge clk);
      chk("R8 single run", DW'(log_n - base), 2);

      // R9 enable masking
      lat = 0;
      wr(ra(1, 0, 0, 3'd3), 32'hF);
      wr(ra(1, 0, 0, 3'd4), 32'hB);
      wr(ra(1, 2, 0, 3'd2), 1);
      wait_pend(4'b0100);
      @(negedge clk); #1;
      chk("R9 masked irq", DW'(irq), 0);
      wr(ra(1, 0, 0, 3'd4), 32'hF);
      #1 chk("R9 enabled irq", DW'(irq), 1);
      wr(ra(1, 0, 0, 3'd3), 32'h4);
      #1 chk("R9 w1c irq", DW'(irq), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule